// File: doc/BRIEF.md
# Console Character I/O Register Block

This block sits on a 16-bit processor's load/store path and presents two character devices as four fixed word addresses. One is a keyboard-style input channel that captures one 8-bit character at a time. The other is a display-style output channel that hands one 8-bit character at a time to a display engine and waits for that engine to acknowledge it. A load from any other address passes the memory read data through unchanged, so the block can sit directly in front of the processor's read-data input.

Each channel has a ready flag, which only hardware changes, and an interrupt-enable flag, which software writes through the channel's status word. The keyboard ready flag rises when a character is captured. Further characters are then dropped until software loads the data word, and that load lowers the flag. The display ready flag falls when software stores a character, and store attempts are ignored until the display engine acknowledges. Each channel raises its own interrupt request while both of its flags are set. Priority selection between requests is left to logic outside the block.

Top module: `console_io_regs`

## Requirements
- R1: While reset is high and on the cycle it is released, both interrupt-enable flags and the keyboard ready flag are 0, and the display ready flag is 1. Both interrupt requests and `dsp_valid` are low, and `dsp_char` is 0.
- R2: The address map is 0xFE00 keyboard status, 0xFE02 keyboard data, 0xFE04 display status and 0xFE06 display data. A status word reads bit 15 = ready and bit 14 = interrupt enable, with bits 13..0 zero. A load from the display data word returns 0. `bus_rdata` follows the current address and state combinationally.
- R3: When `kbd_valid` is high and the keyboard ready flag is 0, the character is captured at that clock edge and the ready flag is 1 from the next cycle. The keyboard data word then reads the character in bits 7..0 and zero in bits 15..8.
- R4: While the keyboard ready flag is 1, characters presented on `kbd_valid`/`kbd_char` are dropped. The stored character does not change, even when the drop happens in the same cycle as a load of the keyboard data word.
- R5: A load (`bus_rd`) of the keyboard data word returns the stored character in that cycle and clears the keyboard ready flag at the clock edge. The next character presented after that edge is captured.
- R6: A store to the display data word while the display ready flag is 1 clears that flag. In the next cycle it drives `dsp_valid` high for exactly one cycle, and `dsp_char` holds bits 7..0 of the stored word until the next accepted store.
- R7: A store to the display data word while the display ready flag is 0 is ignored. No `dsp_valid` pulse follows and `dsp_char` keeps its value.
- R8: `dsp_done` seen while the display ready flag is 0 sets that flag from the next cycle. `dsp_done` while the flag is already 1 has no effect.
- R9: `kbd_irq` equals keyboard ready AND keyboard interrupt-enable, and `dsp_irq` equals display ready AND display interrupt-enable, on every cycle.
- R10: A store to a status word sets that channel's interrupt-enable flag to bit 14 of the stored word from the next cycle. The ready flag ignores bit 15 of the store.
- R11: A load from any address other than the four device words returns `mem_rdata` unchanged. Loads and stores at other addresses, and stores to the keyboard data word, change no channel state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Word address of the current access |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 16 | Store data |
| mem_rdata | input | 16 | Read data from memory, passed through for non-device addresses |
| bus_rdata | output | 16 | Read data returned to the processor |
| kbd_valid | input | 1 | Keyboard side offers a character this cycle |
| kbd_char | input | 8 | Offered character code |
| dsp_valid | output | 1 | One-cycle pulse: a new character is on `dsp_char` |
| dsp_char | output | 8 | Character handed to the display |
| dsp_done | input | 1 | Display can take another character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| dsp_irq | output | 1 | Display interrupt request |

## Verification
Read data is combinational, so each load value is compared one nanosecond after the address is driven, before the clock edge that the load sees. Flag changes from captures, loads, stores, status writes and acknowledges are due one cycle after the stimulus edge. The `dsp_valid` pulse is due one cycle after an accepted store and must be gone one cycle later. The bench drives every stimulus on a falling edge and checks on the next falling edge, which keeps each registered result exactly one rising edge behind its cause. All 256 character codes are swept through both channels, and every combination of ready and interrupt-enable is swept on each channel.

// File: rtl/console_io_pkg.sv
package console_io_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned CHR_W  = 8;

    localparam logic [WORD_W-1:0] KSTAT_ADDR_D = 16'hFE00;
    localparam logic [WORD_W-1:0] KDATA_ADDR_D = 16'hFE02;
    localparam logic [WORD_W-1:0] DSTAT_ADDR_D = 16'hFE04;
    localparam logic [WORD_W-1:0] DDATA_ADDR_D = 16'hFE06;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA
    } reg_sel_e;

    typedef struct packed {
        logic rdy;
        logic ie;
    } chan_stat_t;

    typedef struct packed {
        logic rd_kdata;
        logic wr_kstat;
        logic wr_dstat;
        logic wr_ddata;
    } bus_act_t;

    function automatic logic chan_req(chan_stat_t s);
        return s.rdy & s.ie;
    endfunction

endpackage

// File: rtl/console_io_decode.sv
module console_io_decode
    import console_io_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] KSTAT_ADDR = KSTAT_ADDR_D[ADDR_W-1:0],
    parameter logic [ADDR_W-1:0] KDATA_ADDR = KDATA_ADDR_D[ADDR_W-1:0],
    parameter logic [ADDR_W-1:0] DSTAT_ADDR = DSTAT_ADDR_D[ADDR_W-1:0],
    parameter logic [ADDR_W-1:0] DDATA_ADDR = DDATA_ADDR_D[ADDR_W-1:0]
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_e          sel,
    output bus_act_t          act
);

    always_comb begin
        if (addr == KSTAT_ADDR)      sel = SEL_KSTAT;
        else if (addr == KDATA_ADDR) sel = SEL_KDATA;
        else if (addr == DSTAT_ADDR) sel = SEL_DSTAT;
        else if (addr == DDATA_ADDR) sel = SEL_DDATA;
        else                         sel = SEL_NONE;
    end

    always_comb begin
        act          = '0;
        act.rd_kdata = rd && (sel == SEL_KDATA);
        act.wr_kstat = wr && (sel == SEL_KSTAT);
        act.wr_dstat = wr && (sel == SEL_DSTAT);
        act.wr_ddata = wr && (sel == SEL_DDATA);
    end

endmodule

// File: rtl/console_io_kbd_chan.sv
module console_io_kbd_chan
    import console_io_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              data_rd,
    input  logic              stat_wr,
    input  logic              stat_ie,
    output chan_stat_t        stat,
    output logic [CHAR_W-1:0] held_char
);

    logic take;
    assign take = in_valid && !stat.rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat      <= '0;
            held_char <= '0;
        end else begin
            if (stat_wr)
                stat.ie <= stat_ie;
            if (take) begin
                stat.rdy  <= 1'b1;
                held_char <= in_char;
            end else if (data_rd) begin
                stat.rdy <= 1'b0;
            end
        end
    end

    // R3
    kbd_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stat.rdy) |=> (stat.rdy && held_char == $past(in_char)));

    // R4
    kbd_drop_chk: assert property (@(posedge clk) disable iff (rst)
        stat.rdy |=> $stable(held_char));

    // R5
    kbd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.rdy && data_rd) |=> !stat.rdy);

endmodule

// File: rtl/console_io_dsp_chan.sv
module console_io_dsp_chan
    import console_io_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              done,
    input  logic              stat_wr,
    input  logic              stat_ie,
    output chan_stat_t        stat,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char
);

    logic accept;
    assign accept = data_wr && stat.rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat.rdy  <= 1'b1;
            stat.ie   <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (stat_wr)
                stat.ie <= stat_ie;
            if (accept) begin
                stat.rdy  <= 1'b0;
                out_valid <= 1'b1;
                out_char  <= wr_char;
            end else if (!stat.rdy && done) begin
                stat.rdy <= 1'b1;
            end
        end
    end

    // R6
    dsp_take_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.rdy && data_wr) |=> (out_valid && !stat.rdy && out_char == $past(wr_char)));

    // R7
    dsp_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat.rdy && data_wr) |=> (!out_valid && $stable(out_char)));

    // R8
    dsp_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat.rdy && done) |=> stat.rdy);

    // R6
    dsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
    import console_io_pkg::*;
#(
    parameter int unsigned ADDR_W = WORD_W,
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned CHAR_W = CHR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_char,
    output logic              dsp_valid,
    output logic [CHAR_W-1:0] dsp_char,
    input  logic              dsp_done,
    output logic              kbd_irq,
    output logic              dsp_irq
);

    localparam int unsigned RDY_BIT = DATA_W - 1;
    localparam int unsigned IE_BIT  = DATA_W - 2;
    localparam int unsigned PAD_W   = DATA_W - CHAR_W;

    reg_sel_e          sel;
    bus_act_t          act;
    chan_stat_t        kbd_stat;
    chan_stat_t        dsp_stat;
    logic [CHAR_W-1:0] kbd_held;

    console_io_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .sel  (sel),
        .act  (act)
    );

    console_io_kbd_chan #(.CHAR_W(CHAR_W)) kbd_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (kbd_valid),
        .in_char   (kbd_char),
        .data_rd   (act.rd_kdata),
        .stat_wr   (act.wr_kstat),
        .stat_ie   (bus_wdata[IE_BIT]),
        .stat      (kbd_stat),
        .held_char (kbd_held)
    );

    console_io_dsp_chan #(.CHAR_W(CHAR_W)) dsp_i (
        .clk       (clk),
        .rst       (rst),
        .data_wr   (act.wr_ddata),
        .wr_char   (bus_wdata[CHAR_W-1:0]),
        .done      (dsp_done),
        .stat_wr   (act.wr_dstat),
        .stat_ie   (bus_wdata[IE_BIT]),
        .stat      (dsp_stat),
        .out_valid (dsp_valid),
        .out_char  (dsp_char)
    );

    assign kbd_irq = chan_req(kbd_stat);
    assign dsp_irq = chan_req(dsp_stat);

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_KSTAT: begin
                bus_rdata[RDY_BIT] = kbd_stat.rdy;
                bus_rdata[IE_BIT]  = kbd_stat.ie;
            end
            SEL_KDATA: bus_rdata = {{PAD_W{1'b0}}, kbd_held};
            SEL_DSTAT: begin
                bus_rdata[RDY_BIT] = dsp_stat.rdy;
                bus_rdata[IE_BIT]  = dsp_stat.ie;
            end
            SEL_DDATA: bus_rdata = '0;
            default:   bus_rdata = mem_rdata;
        endcase
    end

    // R9
    kbd_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_KSTAT) |-> (kbd_irq == (bus_rdata[RDY_BIT] && bus_rdata[IE_BIT])));

    // R9
    dsp_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_DSTAT) |-> (dsp_irq == (bus_rdata[RDY_BIT] && bus_rdata[IE_BIT])));

    // R10
    kstat_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_KSTAT && bus_wdata == '0) |=> !kbd_irq);

    // R10
    dstat_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_DSTAT && bus_wdata == '0) |=> !dsp_irq);

endmodule

// File: tb/console_io_regs_tb_top.sv
module console_io_regs_tb_top;

    localparam logic [15:0] A_KS = 16'hFE00;
    localparam logic [15:0] A_KD = 16'hFE02;
    localparam logic [15:0] A_DS = 16'hFE04;
    localparam logic [15:0] A_DD = 16'hFE06;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] bus_rdata;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_char = '0;
    logic        dsp_valid;
    logic [7:0]  dsp_char;
    logic        dsp_done = 1'b0;
    logic        kbd_irq;
    logic        dsp_irq;

    int vec = 0;
    int bad = 0;

    always #2 clk = ~clk;

    console_io_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .mem_rdata(mem_rdata), .bus_rdata(bus_rdata),
        .kbd_valid(kbd_valid), .kbd_char(kbd_char), .dsp_valid(dsp_valid),
        .dsp_char(dsp_char), .dsp_done(dsp_done), .kbd_irq(kbd_irq), .dsp_irq(dsp_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        bus_rd = 1'b0; bus_wr = 1'b0; kbd_valid = 1'b0; dsp_done = 1'b0;
    endtask

    // One load cycle: compares combinational read data before the edge.
    task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk(tag, bus_rdata, exp);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic kin(input logic [7:0] c);
        @(negedge clk);
        kbd_valid = 1'b1; kbd_char = c;
        @(negedge clk);
        idle();
    endtask

    task automatic done_pulse();
        @(negedge clk);
        dsp_done = 1'b1;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is high
        chk("R1 kbd_irq", {15'd0, kbd_irq}, 16'd0);
        chk("R1 dsp_irq", {15'd0, dsp_irq}, 16'd0);
        chk("R1 dsp_valid", {15'd0, dsp_valid}, 16'd0);
        chk("R1 dsp_char", {8'd0, dsp_char}, 16'd0);
        rst = 1'b0;
        rd(A_KS, 16'h0000, "R1 kbd status");
        rd(A_DS, 16'h8000, "R1 dsp status");
        // R2: display data word reads zero
        rd(A_DD, 16'h0000, "R2 ddata read");

        // Keyboard sweep over every code (R3, R4, R5)
        for (int c = 0; c < 256; c++) begin
            kin(8'(c));
            rd(A_KS, 16'h8000, "R3 ready set");
            kin(8'(c) ^ 8'hA5);
            rd(A_KD, {8'h00, 8'(c)}, "R4 drop keeps char");
            rd(A_KS, 16'h0000, "R5 ready cleared");
        end
        // R4: character offered in the same cycle as the clearing load is dropped
        kin(8'h41);
        @(negedge clk);
        bus_addr = A_KD; bus_rd = 1'b1; kbd_valid = 1'b1; kbd_char = 8'h7E;
        #1 chk("R5 load returns char", bus_rdata, 16'h0041);
        @(negedge clk);
        idle();
        rd(A_KS, 16'h0000, "R4 same-cycle drop");
        rd(A_KD, 16'h0041, "R4 char unchanged");
        // R11: store to keyboard data word has no effect
        wr(A_KD, 16'hFFFF);
        rd(A_KD, 16'h0041, "R11 kdata store ignored");
        rd(A_KS, 16'h0000, "R11 kdata store no ready");

        // Display sweep (R6, R7, R8)
        for (int c = 0; c < 256; c++) begin
            wr(A_DD, 16'hAB00 | 16'(c));
            chk("R6 valid pulse", {15'd0, dsp_valid}, 16'd1);
            chk("R6 char", {8'd0, dsp_char}, 16'(c));
            rd(A_DS, 16'h0000, "R6 ready cleared");
            chk("R6 pulse one cycle", {15'd0, dsp_valid}, 16'd0);
            wr(A_DD, 16'(~c) & 16'h00FF);
            chk("R7 no pulse", {15'd0, dsp_valid}, 16'd0);
            chk("R7 char kept", {8'd0, dsp_char}, 16'(c));
            done_pulse();
            rd(A_DS, 16'h8000, "R8 ready set");
        end
        done_pulse();
        rd(A_DS, 16'h8000, "R8 done while ready");
        chk("R8 no pulse", {15'd0, dsp_valid}, 16'd0);

        // Status and request sweep (R9, R10)
        for (int r = 0; r < 2; r++) begin
            for (int e = 0; e < 2; e++) begin
                if (r == 1) kin(8'h55);
                wr(A_KS, (e != 0 ? 16'h4000 : 16'h0000) | (r == 0 ? 16'hBFFF : 16'h3FFF));
                rd(A_KS, {r[0], e[0], 14'd0}, "R10 kbd status write");
                chk("R9 kbd_irq", {15'd0, kbd_irq}, 16'(r & e));
                if (r == 1) rd(A_KD, 16'h0055, "R10 kbd char");
                if (r == 0) wr(A_DD, 16'h0033);
                wr(A_DS, (e != 0 ? 16'h4000 : 16'h0000) | (r == 0 ? 16'hBFFF : 16'h3FFF));
                rd(A_DS, {r[0], e[0], 14'd0}, "R10 dsp status write");
                chk("R9 dsp_irq", {15'd0, dsp_irq}, 16'(r & e));
                if (r == 0) done_pulse();
            end
        end

        // Pass-through and no side effects at other addresses (R11)
        wr(A_KS, 16'h4000);
        wr(A_DS, 16'h4000);
        kin(8'h3C);
        for (int i = 0; i < 18; i++) begin
            logic [15:0] a;
            a = (i < 16) ? (16'hFE00 + 16'(i)) : (i == 16 ? 16'h0000 : 16'hFFFF);
            if (a != A_KS && a != A_KD && a != A_DS && a != A_DD) begin
                mem_rdata = a ^ 16'h1234;
                rd(a, a ^ 16'h1234, "R11 pass-through");
                wr(a, 16'h0000);
            end
        end
        rd(A_KS, 16'hC000, "R11 kbd state kept");
        rd(A_DS, 16'hC000, "R11 dsp state kept");
        chk("R11 no display pulse", {15'd0, dsp_valid}, 16'd0);
        rd(A_KD, 16'h003C, "R11 kbd char kept");

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule